// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shift Unit

This block is a small synchronous serial port built around an 8-bit shift register and a 4-bit transfer counter. The shift register and the counter always step together, driven by whichever of three clock sources software has picked. The sources are the serial clock pin, a one-cycle strobe from a timer compare match, and a register write that acts as a software step. Data moves most significant bit first. The output pin shows the bit now leaving the shift register, and the input pin is captured into bit 0.

The serial clock pin counts both of its edges when it is the selected source. One edge samples incoming data and the opposite edge updates the data output, and a polarity bit selects the SPI mode 0 or mode 1 timing. A full byte therefore takes sixteen counts, and the counter wraps from 15 to 0 at the end of the byte. That wrap sets a sticky flag, which can raise an interrupt. As a master, the unit drives the clock pin from a register bit. Software moves the pin by writing that bit or by writing a toggle bit, so no rate generator is needed. The pin's edges then clock the unit the same way an external clock does. The external clock and data inputs pass through a synchronizer before edge detection, which is done on the system clock. There is no slave-select input.

Top module: `usi_serial_top`

## Requirements
- R1: After synchronous reset, the data, count and control registers read 0, and `sdo`, `sck_out`, `sck_oe` and `irq` are 0.
- R2: Register bus map: address 0 is the shift register (read/write), address 1 holds the counter in bits 3:0 (read/write, upper bits read 0), address 2 is control, and a write to address 3 is a software step. Writes take effect at the clock edge of the write, and reads are combinational.
- R3: Control bit 7 is the overflow flag. A counter step from 15 to 0 sets it. Writing 1 to bit 7 clears it, and a set in the same cycle wins over the clear. A direct counter write never sets it. `irq` equals the flag AND control bit 6.
- R4: Control bits 1:0 select the clock: 0 is off, 1 is the clock pin, 2 is `tmr_strobe`, 3 is an address-3 write. The sources that are not selected change neither the data nor the count.
- R5: With the pin source selected, the counter increments once for every rising edge and once for every falling edge of the clock level. Each edge takes effect within four system clocks of the pin change.
- R6: With the pin source selected, the sample edge shifts the register left and puts the synchronized `sdi` into bit 0. The opposite edge loads `sdo` from bit 7. With control bit 2 at 0, rising edges sample and falling edges drive (mode 0); with bit 2 at 1, the roles swap (mode 1). A data write loads `sdo` with the written bit 7.
- R7: With the timer or software source, each strobe shifts in one bit, adds one to the counter, and loads `sdo` with the new bit 7.
- R8: With control bit 3 set, the unit is master: `sck_oe` is 1 and `sck_out` shows control bit 4. Writing 1 to bit 5 inverts the clock level instead of loading bit 4, and bit 5 reads 0. The pin source then takes its edges from this level.
- R9: In either SPI mode, sixteen clock edges emit the loaded byte on `sdo` MSB first, leave the received byte in the shift register, return the counter to 0 and set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sck_in | input | 1 | Serial clock pin level as received |
| sck_out | output | 1 | Serial clock level driven in master mode |
| sck_oe | output | 1 | Serial clock driver enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tmr_strobe | input | 1 | One-cycle timer compare-match strobe |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong shift-register state shows first on `sdo`, at the next drive edge. It then shows in the data read after the byte completes. A wrong edge count shows as a counter value off by one, read back within a few cycles, or as an overflow flag that is early or late by one edge. A fault in the polarity or edge-detection logic swaps the sample and drive roles, so the emitted byte loses or repeats a bit inside one transfer. Exchanges of random bytes in both modes show this directly.

// File: rtl/usi_pkg.sv
package usi_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_PIN   = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_STEP  = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_STEP  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic     flag;
        logic     irq_en;
        logic     toggle;
        logic     port_lvl;
        logic     master;
        logic     pol;
        clk_src_e src;
    } ctrl_t;

    typedef struct packed {
        logic shift;
        logic drive;
        logic count;
    } tick_t;

    function automatic tick_t pin_ticks(input logic rise, input logic fall,
                                        input logic pol);
        tick_t t;
        t.shift = pol ? fall : rise;
        t.drive = pol ? rise : fall;
        t.count = rise | fall;
        return t;
    endfunction

endpackage

// File: rtl/usi_sync.sv
module usi_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/usi_clk_ctl.sv
module usi_clk_ctl
    import usi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src,
    input  logic     pol,
    input  logic     master,
    input  logic     port_lvl,
    input  logic     sck_sync,
    input  logic     tmr_strobe,
    input  logic     step_wr,
    output tick_t    ticks
);
    logic pin_lvl, prev_q, rise, fall;

    assign pin_lvl = master ? port_lvl : sck_sync;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_lvl;
    end

    assign rise = pin_lvl & ~prev_q;
    assign fall = ~pin_lvl & prev_q;

    always_comb begin
        unique case (src)
            SRC_PIN:   ticks = pin_ticks(rise, fall, pol);
            SRC_TIMER: ticks = '{shift: tmr_strobe, drive: tmr_strobe, count: tmr_strobe};
            SRC_STEP:  ticks = '{shift: step_wr, drive: step_wr, count: step_wr};
            default:   ticks = '0;
        endcase
    end

    // R6
    edge_role_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PIN) |-> !(ticks.shift && ticks.drive));

    // R4
    idle_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PIN && $stable(pin_lvl)) |-> !ticks.count);
endmodule

// File: rtl/usi_shift_core.sv
module usi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         drive,
    input  logic         sin,
    output logic [W-1:0] sr,
    output logic         sdo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            sdo <= 1'b0;
        end else if (load) begin
            sr  <= load_val;
            sdo <= load_val[W-1];
        end else begin
            if (shift) sr <= {sr[W-2:0], sin};
            if (drive) sdo <= shift ? sr[W-2] : sr[W-1];
        end
    end

    // R6
    shift_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (sr == {$past(sr[W-2:0]), $past(sin)}));

    // R6
    load_out_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdo == $past(load_val[W-1])));
endmodule

// File: rtl/usi_xfer_counter.sv
module usi_xfer_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          wr,
    input  logic [CW-1:0] wval,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          flag
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic wrap;
    assign wrap = inc && !wr && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (wr)  cnt <= wval;
        else if (inc) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr && cnt == CNT_MAX) |=> (flag && cnt == '0));

    // R3
    write_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !flag) |=> !flag);

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/usi_serial_top.sv
module usi_serial_top
    import usi_pkg::*;
#(
    parameter int CNT_W_P     = usi_pkg::CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    input  logic              tmr_strobe,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W_P;

    reg_addr_e addr;
    ctrl_t     wctrl;
    logic      wr_data, wr_cnt, wr_ctrl, wr_step;

    assign addr    = reg_addr_e'(bus_addr);
    assign wctrl   = ctrl_t'(bus_wdata);
    assign wr_data = bus_wr && addr == REG_DATA;
    assign wr_cnt  = bus_wr && addr == REG_COUNT;
    assign wr_ctrl = bus_wr && addr == REG_CTRL;
    assign wr_step = bus_wr && addr == REG_STEP;

    clk_src_e src_q;
    logic     pol_q, master_q, port_q, irq_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= SRC_OFF;
            pol_q    <= 1'b0;
            master_q <= 1'b0;
            port_q   <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (wr_ctrl) begin
            src_q    <= wctrl.src;
            pol_q    <= wctrl.pol;
            master_q <= wctrl.master;
            port_q   <= wctrl.toggle ? ~port_q : wctrl.port_lvl;
            irq_en_q <= wctrl.irq_en;
        end
    end

    logic [1:0] pins_sync;

    usi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_in, sdi}),
        .q   (pins_sync)
    );

    tick_t ticks;

    usi_clk_ctl u_clk (
        .clk        (clk),
        .rst        (rst),
        .src        (src_q),
        .pol        (pol_q),
        .master     (master_q),
        .port_lvl   (port_q),
        .sck_sync   (pins_sync[1]),
        .tmr_strobe (tmr_strobe),
        .step_wr    (wr_step),
        .ticks      (ticks)
    );

    logic [DATA_W-1:0] sr;

    usi_shift_core #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_data),
        .load_val (bus_wdata),
        .shift    (ticks.shift),
        .drive    (ticks.drive),
        .sin      (pins_sync[0]),
        .sr       (sr),
        .sdo      (sdo)
    );

    logic [CNT_W_P-1:0] cnt;
    logic               flag;

    usi_xfer_counter #(.CW(CNT_W_P)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ticks.count),
        .wr   (wr_cnt),
        .wval (bus_wdata[CNT_W_P-1:0]),
        .clr  (wr_ctrl && wctrl.flag),
        .cnt  (cnt),
        .flag (flag)
    );

    ctrl_t rctrl;
    assign rctrl = '{flag: flag, irq_en: irq_en_q, toggle: 1'b0, port_lvl: port_q,
                     master: master_q, pol: pol_q, src: src_q};

    always_comb begin
        unique case (addr)
            REG_DATA:  bus_rdata = sr;
            REG_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt};
            REG_CTRL:  bus_rdata = rctrl;
            default:   bus_rdata = '0;
        endcase
    end

    assign sck_out = port_q;
    assign sck_oe  = master_q;
    assign irq     = flag & irq_en_q;

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cnt) == {CNT_W_P{1'b1}} && cnt == '0));

    // R8
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wctrl.toggle) |=> (sck_out != $past(sck_out)));
endmodule

// File: tb/tb_usi_serial_top.sv
module tb_usi_serial_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_in = 1'b0;
    logic       sck_out, sck_oe, sdo, irq;
    logic       sdi = 1'b0;
    logic       tmr_strobe = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usi_serial_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
        .tmr_strobe(tmr_strobe), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
        return {cur[6:0], b};
    endfunction

    // Sixteen-edge exchange, pol selects SPI mode 0 or 1
    task automatic xfer(input logic pol, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] seen, v;
        wr(2'd2, {5'b0, pol, 2'd1});
        wr(2'd0, tx);
        wr(2'd1, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            if (!pol) begin
                sdi = rx[i]; idle(4);
                seen[i] = sdo;
                sck_in = 1'b1; idle(4);
                sck_in = 1'b0; idle(4);
            end else begin
                sck_in = 1'b1; idle(4);
                seen[i] = sdo;
                sdi = rx[i]; idle(2);
                sck_in = 1'b0; idle(4);
            end
        end
        chk(pol ? "R9 mode1 sdo stream" : "R9 mode0 sdo stream", seen, tx);
        rd(2'd0, v); chk("R9 R6 received byte", v, rx);
        rd(2'd1, v); chk("R5 count after 16 edges", v, 8'h00);
        rd(2'd2, v); chk("R3 flag after wrap", {7'b0, v[7]}, 8'h01);
        wr(2'd2, {1'b1, 4'b0, pol, 2'd1});
        rd(2'd2, v); chk("R3 flag cleared", {7'b0, v[7]}, 8'h00);
    endtask

    // Strobe-driven bits; use_tmr picks timer vs software step
    task automatic strobe_run(input logic use_tmr, input logic [7:0] start, input int n);
        logic [7:0] exp, v, bits;
        bits = 8'($urandom);
        exp = start;
        wr(2'd2, use_tmr ? 8'h02 : 8'h03);
        wr(2'd0, start);
        wr(2'd1, 8'h00);
        for (int k = 0; k < n; k++) begin
            sdi = bits[k]; idle(3);
            if (use_tmr) begin
                @(negedge clk); tmr_strobe = 1'b1;
                @(negedge clk); tmr_strobe = 1'b0;
            end else begin
                wr(2'd3, 8'h00);
            end
            exp = shift_in(exp, bits[k]);
        end
        idle(1);
        rd(2'd0, v); chk("R7 data after strobes", v, exp);
        rd(2'd1, v); chk("R7 count after strobes", v, 8'(n));
        chk("R7 sdo after strobes", {7'b0, sdo}, {7'b0, exp[7]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, d0, c0;
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        rd(2'd0, v); chk("R1 data reset", v, 8'h00);
        rd(2'd1, v); chk("R1 count reset", v, 8'h00);
        rd(2'd2, v); chk("R1 ctrl reset", v, 8'h00);
        chk("R1 pins reset", {4'b0, sdo, sck_out, sck_oe, irq}, 8'h00);

        // R2 register access
        wr(2'd0, 8'hA5); rd(2'd0, v); chk("R2 data rw", v, 8'hA5);
        chk("R6 sdo on data write", {7'b0, sdo}, 8'h01);
        wr(2'd1, 8'hFB); rd(2'd1, v); chk("R2 count rw masked", v, 8'h0B);
        wr(2'd2, 8'h14); rd(2'd2, v); chk("R2 ctrl rw", v, 8'h14);
        wr(2'd2, 8'h00);

        // R3 flag by wrap, irq enable, write-one clear, count write no flag
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h0F);
        rd(2'd2, v); chk("R3 count write sets no flag", {7'b0, v[7]}, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd1, v); chk("R3 wrap to zero", v, 8'h00);
        rd(2'd2, v); chk("R3 flag set on wrap", {7'b0, v[7]}, 8'h01);
        chk("R3 irq masked", {7'b0, irq}, 8'h00);
        wr(2'd2, 8'h43); idle(1);
        chk("R3 irq enabled", {7'b0, irq}, 8'h01);
        wr(2'd2, 8'hC3); idle(1);
        chk("R3 irq after clear", {7'b0, irq}, 8'h00);

        // R4 unselected sources ignored
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h3C); wr(2'd1, 8'h05);
        sdi = 1'b1;
        @(negedge clk); tmr_strobe = 1'b1; @(negedge clk); tmr_strobe = 1'b0;
        sck_in = 1'b1; idle(5); sck_in = 1'b0; idle(5);
        rd(2'd0, v); chk("R4 step mode ignores timer and pin data", v, 8'h3C);
        rd(2'd1, v); chk("R4 step mode ignores timer and pin count", v, 8'h05);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        @(negedge clk); tmr_strobe = 1'b1; @(negedge clk); tmr_strobe = 1'b0;
        sck_in = 1'b1; idle(5); sck_in = 1'b0; idle(5);
        rd(2'd0, d0); rd(2'd1, c0);
        chk("R4 off mode ignores all", {d0[3:0], c0[3:0]}, 8'hC5);
        wr(2'd2, 8'h02); wr(2'd3, 8'h00);
        rd(2'd1, v); chk("R4 timer mode ignores step", v, 8'h05);

        // R5 single edges counted within four cycles
        wr(2'd2, 8'h01); wr(2'd1, 8'h00);
        sck_in = 1'b1; idle(4);
        rd(2'd1, v); chk("R5 rising edge counted", v, 8'h01);
        sck_in = 1'b0; idle(4);
        rd(2'd1, v); chk("R5 falling edge counted", v, 8'h02);

        // R9 R6 directed and random exchanges in both modes
        xfer(1'b0, 8'h80, 8'h01);
        xfer(1'b1, 8'h01, 8'h80);
        for (int it = 0; it < 4; it++) begin
            xfer(1'b0, 8'($urandom), 8'($urandom));
            xfer(1'b1, 8'($urandom), 8'($urandom));
        end

        // R7 strobe sources
        for (int it = 0; it < 6; it++)
            strobe_run(it[0], 8'($urandom), 1 + int'($urandom % 8));

        // R8 master clock generation
        wr(2'd2, 8'h09); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        idle(1);
        chk("R8 master pins idle", {6'b0, sck_oe, sck_out}, 8'h02);
        sdi = 1'b1; idle(3);
        wr(2'd2, 8'h29); idle(3);
        chk("R8 toggle raises clock", {7'b0, sck_out}, 8'h01);
        rd(2'd1, v); chk("R8 toggle edge counted", v, 8'h01);
        rd(2'd2, v); chk("R8 toggle reads zero", {7'b0, v[5]}, 8'h00);
        wr(2'd2, 8'h29); idle(3);
        chk("R8 toggle lowers clock", {7'b0, sck_out}, 8'h00);
        wr(2'd2, 8'h19); idle(3);
        rd(2'd1, v); chk("R8 port write edge counted", v, 8'h03);
        rd(2'd0, v); chk("R8 master sampled sdi", v, 8'h03);
        wr(2'd2, 8'h00);
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule